// File: doc/BRIEF.md
# Byte Multiplier with Signed Correction

This unit sits in the datapath of an 8-bit processor and multiplies the working register by a second byte operand. The multiply core is purely unsigned. In unsigned mode the full double-width product is written into a high/low product register pair at the clock edge that accepts the start strobe, so the operation finishes in one cycle.

In signed mode the same unsigned product is loaded first. A small sequencer then walks five more steps. If the second operand is negative, the first operand is subtracted modulo 256 from the high product byte. After that, if the first operand is negative, the second operand is subtracted from the high byte. When the sequence ends, the pair holds the two's-complement product. The operands are captured when the operation is accepted. The low byte is written only by the core. The unit has no status flag outputs of any kind.

Top module: `bmul_unit`

## Requirements
- R1: While reset is high and after it is released, both product bytes read 0x00, busy_o is 0 and done_o is 0.
- R2: In unsigned mode (signed_i = 0), a start accepted at a clock edge makes {prod_hi_o, prod_lo_o} equal to wreg_i × arg_i (unsigned, 16 bits) after that same edge. done_o is 1 for the following cycle and busy_o stays 0.
- R3: In signed mode (signed_i = 1), after the sixth clock edge counted from and including the accepting edge, {prod_hi_o, prod_lo_o} equals the 16-bit two's-complement product of the two operands. done_o is 1 in that cycle and busy_o is 0.
- R4: During a signed operation, busy_o is 1 in each of the five cycles that follow the accepting edge, and done_o is 0 in those cycles.
- R5: The signed corrections never modify prod_lo_o. It equals the low byte of the unsigned product throughout the operation.
- R6: The operands are captured when a start is accepted. Changes on wreg_i, arg_i or signed_i while busy_o is 1 have no effect on the result.
- R7: A start that arrives while busy_o is 1 is ignored. The running operation completes with its own result at its own time.
- R8: done_o is a single-cycle pulse. It falls in the cycle after completion unless a new unsigned operation completes at that edge.
- R9: With no start, both product bytes hold their last value.
- R10: In signed mode, in the cycle right after the accepting edge, the product bytes hold the uncorrected unsigned product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe; accepted when busy_o is 0 |
| signed_i | input | 1 | 1 = two's-complement operation, 0 = unsigned |
| wreg_i | input | 8 | Operand from the working register |
| arg_i | input | 8 | Operand supplied with the command |
| busy_o | output | 1 | Signed correction sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| prod_hi_o | output | 8 | High product byte |
| prod_lo_o | output | 8 | Low product byte |

## Verification
The bench covers every unsigned operand pair with back-to-back starts. A design that registered an extra stage, or dropped a start issued in the done cycle, would misalign against the expected products. Signed mode uses the sign corners: 0x80 × 0x80 gives 0x4000, 0xFF × 0x01 gives 0xFFFF, and there are mixed-sign and zero cases. A wrong subtraction order or a missed sign test shows up in the high byte. During each signed operation the bench scrambles the operand inputs and issues a stray start. A design that did not latch its operands, or that restarted, would produce a foreign product or an early done. The bench also checks the uncorrected intermediate product, a stable low byte and the busy window, so a sequence of the wrong length is caught.

// File: rtl/bmul_pkg.sv
package bmul_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TSTB,
    ST_SUBB,
    ST_MOVE,
    ST_TSTA,
    ST_SUBA
  } bmul_state_t;
endpackage

// File: rtl/bmul_core.sv
module bmul_core #(
  parameter int W = 8,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [PW-1:0] p_o
);
  always_comb begin
    p_o = PW'(a_i) * PW'(b_i);
  end
endmodule

// File: rtl/bmul_fix.sv
module bmul_fix #(
  parameter int W = 8
) (
  input  logic         en_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] sub_i,
  output logic [W-1:0] hi_o
);
  always_comb begin
    hi_o = en_i ? (hi_i - sub_i) : hi_i;
  end
endmodule

// File: rtl/bmul_seq.sv
module bmul_seq
  import bmul_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic signed_i,
  output logic accept_o,
  output logic step_b_o,
  output logic step_a_o,
  output logic busy_o,
  output logic done_o
);
  bmul_state_t state_q;
  logic        done_q;

  assign busy_o   = (state_q != ST_IDLE);
  assign accept_o = start_i && !busy_o;
  assign step_b_o = (state_q == ST_SUBB);
  assign step_a_o = (state_q == ST_SUBA);
  assign done_o   = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            if (signed_i) state_q <= ST_TSTB;
            else          done_q  <= 1'b1;
          end
        end
        ST_TSTB: state_q <= ST_SUBB;
        ST_SUBB: state_q <= ST_MOVE;
        ST_MOVE: state_q <= ST_TSTA;
        ST_TSTA: state_q <= ST_SUBA;
        ST_SUBA: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: once running, busy stays up until the last correction step
  p_busy_window_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && state_q != ST_SUBA) |=> busy_o);

  // R3: the last correction step ends in a done pulse with busy low
  p_done_after_fix_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SUBA) |=> (done_o && !busy_o));

  // R2: an accepted unsigned start completes at the next edge
  p_unsigned_one_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && !signed_i) |=> (done_o && !busy_o));

  // R7: a start while running does not restart the sequence
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (start_i && state_q == ST_TSTB) |=> (state_q == ST_SUBB));
endmodule

// File: rtl/bmul_unit.sv
module bmul_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] wreg_i,
  input  logic [W-1:0] arg_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] prod_hi_o,
  output logic [W-1:0] prod_lo_o
);
  localparam int PW = 2 * W;

  logic [W-1:0]  op_a_q, op_b_q;
  logic [W-1:0]  hi_q, lo_q;
  logic [PW-1:0] raw_prod;
  logic [W-1:0]  fixed_hi, sub_val;
  logic          fix_en;
  logic          accept, step_b, step_a;

  bmul_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .signed_i (signed_i),
    .accept_o (accept),
    .step_b_o (step_b),
    .step_a_o (step_a),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  bmul_core #(.W(W)) u_core (
    .a_i (wreg_i),
    .b_i (arg_i),
    .p_o (raw_prod)
  );

  // step B: second operand negative -> subtract first; step A: the reverse
  always_comb begin
    fix_en  = (step_b && op_b_q[W-1]) || (step_a && op_a_q[W-1]);
    sub_val = step_b ? op_a_q : op_b_q;
  end

  bmul_fix #(.W(W)) u_fix (
    .en_i  (fix_en),
    .hi_i  (hi_q),
    .sub_i (sub_val),
    .hi_o  (fixed_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_a_q <= '0;
      op_b_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (accept) begin
      op_a_q <= wreg_i;
      op_b_q <= arg_i;
      hi_q   <= raw_prod[PW-1:W];
      lo_q   <= raw_prod[W-1:0];
    end else begin
      hi_q   <= fixed_hi;
    end
  end

  assign prod_hi_o = hi_q;
  assign prod_lo_o = lo_q;

  // R5: the low byte is frozen while corrections run
  p_lo_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(lo_q));

  // R6: latched operands do not move during a running operation
  p_ops_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> ($stable(op_a_q) && $stable(op_b_q)));

  // R9: product bytes hold when idle and no start arrives
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: tb/sim_bmul_unit.sv
module sim_bmul_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       signed_i = 1'b0;
  logic [7:0] wreg_i = '0;
  logic [7:0] arg_i = '0;
  logic       busy_o, done_o;
  logic [7:0] prod_hi_o, prod_lo_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bmul_unit u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .signed_i(signed_i),
    .wreg_i(wreg_i), .arg_i(arg_i), .busy_o(busy_o), .done_o(done_o),
    .prod_hi_o(prod_hi_o), .prod_lo_o(prod_lo_o)
  );

  function automatic logic [15:0] umul(logic [7:0] a, logic [7:0] b);
    return 16'(a) * 16'(b);
  endfunction

  function automatic logic [15:0] smul(logic [7:0] a, logic [7:0] b);
    logic signed [15:0] sa, sb;
    sa = {{8{a[7]}}, a};
    sb = {{8{b[7]}}, b};
    return 16'(sa * sb);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // one signed operation; optional scrambling and stray start while busy
  task automatic run_signed(logic [7:0] a, logic [7:0] b, bit disturb);
    logic [15:0] u, s;
    u = umul(a, b);
    s = smul(a, b);
    @(negedge clk);
    start_i = 1'b1; signed_i = 1'b1; wreg_i = a; arg_i = b;
    @(negedge clk);
    start_i = 1'b0;
    chk("R10 hi", prod_hi_o, u[15:8]);
    chk("R5 lo", prod_lo_o, u[7:0]);
    chk("R4 busy", busy_o, 1);
    if (disturb) begin
      wreg_i = ~a; arg_i = b + 8'd37; signed_i = 1'b0; // R6 scramble
    end
    for (int k = 2; k <= 5; k++) begin
      if (disturb && k == 3) start_i = 1'b1;           // R7 stray start
      @(negedge clk);
      start_i = 1'b0;
      chk("R4 busy", busy_o, 1);
      chk("R4 no done", done_o, 0);
      chk("R5 lo", prod_lo_o, u[7:0]);
    end
    @(negedge clk);
    chk("R3 done", done_o, 1);
    chk("R3 busy", busy_o, 0);
    chk(disturb ? "R6 R7 product" : "R3 product", {prod_hi_o, prod_lo_o}, s);
    @(negedge clk);
    chk("R8 done falls", done_o, 0);
    chk("R9 hold", {prod_hi_o, prod_lo_o}, s);
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] pend_exp;
    bit pend;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset hi", prod_hi_o, 0);
    chk("R1 reset lo", prod_lo_o, 0);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset done", done_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {busy_o, done_o, prod_hi_o, prod_lo_o}, 0);

    // R2: every unsigned pair, back to back
    pend = 1'b0;
    pend_exp = '0;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        start_i = 1'b1; signed_i = 1'b0; wreg_i = 8'(a); arg_i = 8'(b);
        @(negedge clk);
        chk("R2 product", {prod_hi_o, prod_lo_o}, umul(8'(a), 8'(b)));
        chk("R2 done/busy", {done_o, busy_o}, 2'b10);
      end
    end
    start_i = 1'b0;
    @(negedge clk);
    chk("R8 done falls", done_o, 0);
    chk("R9 hold", {prod_hi_o, prod_lo_o}, 16'hFE01);
    if (pend) chk("unused", pend_exp, 0);

    // R3 corners
    run_signed(8'h80, 8'h80, 1'b0);
    chk("R3 -128*-128", {prod_hi_o, prod_lo_o}, 16'h4000);
    run_signed(8'hFF, 8'h01, 1'b0);
    chk("R3 -1*1", {prod_hi_o, prod_lo_o}, 16'hFFFF);
    run_signed(8'h7F, 8'h80, 1'b0);
    run_signed(8'h80, 8'h7F, 1'b0);
    run_signed(8'h00, 8'hFF, 1'b0);
    run_signed(8'hFF, 8'hFF, 1'b1);
    run_signed(8'h05, 8'hFD, 1'b1);

    // random signed, half of them disturbed
    for (int n = 0; n < 4000; n++) begin
      run_signed(8'($urandom), 8'($urandom), n[0]);
    end
    finish_run();
  end
endmodule